// File: doc/BRIEF.md
# Location Monitor with Isolation Mode

This block watches decoded slave accesses arriving from the backplane for writes to a monitor location. The monitor is the top longword of each slave window: one window decoded with 24 address bits and one decoded with 32 bits. Each window has its own enable and its own configured top-longword address. A write of any value to that location records a small entry in a four-deep FIFO. The same write also takes the board out of isolation mode.

Isolation mode is set at reset and again whenever software pulses the isolation-set bit. While it is active, every outbound cycle the local processor requests toward the backplane is flagged as blocked. An external monitor write is the only way to leave isolation mode.

Software reads monitor entries through a separate pop strobe that removes the oldest entry. A plain read of the monitor address changes nothing. A monitor write that finds the FIFO full still ends isolation mode. Its entry is discarded and a sticky overflow flag is raised.

Top module: `locmon_iso`

## Requirements
- R1: After reset, `iso_stat` is 1, `fifo_empty` is 1, `fifo_full` is 0 and `fifo_ovf` is 0.
- R2: A monitor write is a slave access with `slv_valid`=1 and `slv_write`=1 that meets all of the following: the window selected by `slv_space` (0 = 24-bit window, 1 = 32-bit window) is enabled; the address bits above bit 1 equal those of the configured top longword (bits 23:2 for the 24-bit window, bits 31:2 for the 32-bit window); and `slv_addr[1:0]` is 0. A longword access and a word access both match. Any other access, including one at byte offset 2 or to a disabled window, is not a monitor write.
- R3: A monitor write clears `iso_stat` on the following cycle.
- R4: A pulse on `iso_set` sets `iso_stat` on the following cycle. It wins over a monitor write in the same cycle, although that write still records its entry.
- R5: `cpu_block` equals `cpu_req` AND `iso_stat` in the same cycle.
- R6: Each accepted monitor write appends the entry {window, size} at the FIFO tail: bit 1 is `slv_space` and bit 0 is `slv_long` (1 = longword, 0 = word). `fifo_data` shows the oldest entry whenever `fifo_empty` is 0.
- R7: A `fifo_rd` pulse while the FIFO is not empty removes the oldest entry, so entries come out in arrival order. A `fifo_rd` pulse while the FIFO is empty has no effect.
- R8: A slave read of the monitor address changes neither the FIFO nor `iso_stat`.
- R9: The FIFO holds 4 entries. `fifo_full` is 1 exactly when it holds 4 entries, and `fifo_empty` is 1 exactly when it holds none.
- R10: A monitor write while the FIFO is full still clears isolation mode. Its entry is discarded even if a pop occurs in the same cycle, and `fifo_ovf` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slv_valid | input | 1 | Decoded slave access present this cycle |
| slv_write | input | 1 | 1 = write, 0 = read |
| slv_space | input | 1 | 0 = 24-bit window, 1 = 32-bit window |
| slv_long | input | 1 | 1 = longword access, 0 = word access |
| slv_addr | input | 32 | Slave access address |
| win24_en | input | 1 | 24-bit window enabled |
| win32_en | input | 1 | 32-bit window enabled |
| mon24_addr | input | 24 | Top-longword address of the 24-bit window |
| mon32_addr | input | 32 | Top-longword address of the 32-bit window |
| iso_set | input | 1 | Software pulse that enters isolation mode |
| fifo_rd | input | 1 | Pop the oldest monitor entry |
| cpu_req | input | 1 | Local processor requests an outbound cycle |
| fifo_data | output | 2 | Oldest entry: {window, size} |
| fifo_empty | output | 1 | FIFO holds no entries |
| fifo_full | output | 1 | FIFO holds 4 entries |
| fifo_ovf | output | 1 | Sticky: a monitor write was dropped |
| iso_stat | output | 1 | Isolation mode active |
| cpu_block | output | 1 | Outbound cycle suppressed |

## Verification
`cpu_block` is combinational, so the bench checks it in the same cycle that `cpu_req` is driven. A monitor write, an `iso_set` pulse or a pop takes effect at the next rising edge. From that edge on, `iso_stat`, `fifo_data`, the flags and `fifo_ovf` show the new state. The bench drives each stimulus at a falling edge and removes it at the next falling edge. It samples the outputs there, half a period after the edge that registered the stimulus. Stimuli that should have no effect (reads, misses, pops on an empty FIFO) are checked in the same way, by looking at the flags and the head entry at that point.

// File: rtl/locmon_iso.sv
module locmon_iso #(
  parameter int unsigned DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slv_valid,
  input  logic        slv_write,
  input  logic        slv_space,
  input  logic        slv_long,
  input  logic [31:0] slv_addr,
  input  logic        win24_en,
  input  logic        win32_en,
  input  logic [23:0] mon24_addr,
  input  logic [31:0] mon32_addr,
  input  logic        iso_set,
  input  logic        fifo_rd,
  input  logic        cpu_req,
  output logic [1:0]  fifo_data,
  output logic        fifo_empty,
  output logic        fifo_full,
  output logic        fifo_ovf,
  output logic        iso_stat,
  output logic        cpu_block
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [1:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          iso_q, ovf_q;

  logic hit24, hit32, mon_hit, mon_wr, push, pop;

  assign hit24   = win24_en && (slv_addr[23:2] == mon24_addr[23:2]);
  assign hit32   = win32_en && (slv_addr[31:2] == mon32_addr[31:2]);
  assign mon_hit = slv_valid && (slv_addr[1:0] == 2'b00) && (slv_space ? hit32 : hit24);
  assign mon_wr  = mon_hit && slv_write;

  assign fifo_empty = (count == '0);
  assign fifo_full  = (count == CNT_FULL);
  assign pop  = fifo_rd && !fifo_empty;
  assign push = mon_wr && !fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {slv_space, slv_long};
  end

  assign fifo_data = fifo_empty ? 2'b00 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iso_q <= 1'b1;
      ovf_q <= 1'b0;
    end else begin
      if (iso_set)     iso_q <= 1'b1;
      else if (mon_wr) iso_q <= 1'b0;
      if (mon_wr && fifo_full) ovf_q <= 1'b1;
    end
  end

  assign iso_stat  = iso_q;
  assign fifo_ovf  = ovf_q;
  assign cpu_block = cpu_req && iso_q;

  // R3
  iso_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_wr && !iso_set) |=> !iso_stat);

  // R4
  iso_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iso_set |=> iso_stat);

  // R5
  block_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_block |-> (iso_stat && cpu_req));

  // R8
  read_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_valid && !slv_write && !fifo_rd && !iso_set) |=> ($stable(count) && $stable(iso_stat)));

  // R7
  pop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && !fifo_empty && !mon_wr) |=> (count == $past(count) - 1'b1));

  // R9
  bound_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_wr && fifo_full) |=> (fifo_ovf && $stable(wr_ptr)));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);

endmodule

// File: tb/sim_locmon_iso.sv
module sim_locmon_iso;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic slv_valid = 0, slv_write = 0, slv_space = 0, slv_long = 0;
  logic [31:0] slv_addr = '0;
  logic win24_en = 1, win32_en = 1;
  logic [23:0] mon24_addr = 24'h3FFFFC;
  logic [31:0] mon32_addr = 32'h083FFFFC;
  logic iso_set = 0, fifo_rd = 0, cpu_req = 0;
  logic [1:0] fifo_data;
  logic fifo_empty, fifo_full, fifo_ovf, iso_stat, cpu_block;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  locmon_iso u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic sp, input logic lg,
                     input logic [31:0] a, input logic set_too);
    @(negedge clk);
    slv_valid = 1; slv_write = wr; slv_space = sp; slv_long = lg;
    slv_addr = a; iso_set = set_too;
    @(negedge clk);
    slv_valid = 0; slv_write = 0; iso_set = 0;
  endtask

  task automatic pulse_set();
    @(negedge clk); iso_set = 1;
    @(negedge clk); iso_set = 0;
  endtask

  task automatic pop_chk(input string req, input logic [1:0] exp);
    chk(req, {31'b0, fifo_empty}, 32'd0);
    chk(req, {30'b0, fifo_data}, {30'b0, exp});
    @(negedge clk); fifo_rd = 1;
    @(negedge clk); fifo_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 iso", {31'b0, iso_stat}, 1);
    chk("R1 empty", {31'b0, fifo_empty}, 1);
    chk("R1 full", {31'b0, fifo_full}, 0);
    chk("R1 ovf", {31'b0, fifo_ovf}, 0);
  endtask

  task automatic t_block(input logic exp_iso);
    cpu_req = 1; #1;
    chk("R5 block req", {31'b0, cpu_block}, {31'b0, exp_iso});
    cpu_req = 0; #1;
    chk("R5 block idle", {31'b0, cpu_block}, 0);
  endtask

  task automatic t_miss();
    acc(1, 1, 1, mon32_addr + 32'd2, 0);
    chk("R2 offset2 iso", {31'b0, iso_stat}, 1);
    chk("R2 offset2 empty", {31'b0, fifo_empty}, 1);
    win24_en = 0;
    acc(1, 0, 1, {8'h00, mon24_addr}, 0);
    win24_en = 1;
    chk("R2 disabled iso", {31'b0, iso_stat}, 1);
    chk("R2 disabled empty", {31'b0, fifo_empty}, 1);
    acc(1, 0, 1, {8'h00, mon24_addr} - 32'd4, 0);
    chk("R2 below top", {31'b0, fifo_empty}, 1);
  endtask

  task automatic t_read_empty();
    acc(0, 1, 1, mon32_addr, 0);
    chk("R8 read iso", {31'b0, iso_stat}, 1);
    chk("R8 read empty", {31'b0, fifo_empty}, 1);
  endtask

  task automatic t_hit32();
    acc(1, 1, 1, mon32_addr, 0);
    chk("R3 cleared", {31'b0, iso_stat}, 0);
    chk("R6 entry", {30'b0, fifo_data}, 32'd3);
    acc(0, 1, 1, mon32_addr, 0);
    chk("R8 read keeps entry", {31'b0, fifo_empty}, 0);
    pop_chk("R7 pop", 2'b11);
    chk("R7 now empty", {31'b0, fifo_empty}, 1);
    @(negedge clk); fifo_rd = 1;
    @(negedge clk); fifo_rd = 0;
    chk("R7 empty pop empty", {31'b0, fifo_empty}, 1);
    chk("R7 empty pop full", {31'b0, fifo_full}, 0);
  endtask

  task automatic t_set();
    pulse_set();
    chk("R4 set", {31'b0, iso_stat}, 1);
  endtask

  task automatic t_order();
    acc(1, 0, 0, {8'h00, mon24_addr}, 0);
    acc(1, 1, 0, mon32_addr, 0);
    acc(1, 0, 1, {8'h00, mon24_addr}, 0);
    chk("R3 word hit clears", {31'b0, iso_stat}, 0);
    pop_chk("R7 order 1", 2'b00);
    pop_chk("R7 order 2", 2'b10);
    pop_chk("R7 order 3", 2'b01);
    chk("R9 empty after drain", {31'b0, fifo_empty}, 1);
  endtask

  task automatic t_full();
    acc(1, 0, 0, {8'h00, mon24_addr}, 0);
    acc(1, 0, 1, {8'h00, mon24_addr}, 0);
    acc(1, 1, 0, mon32_addr, 0);
    chk("R9 not full at 3", {31'b0, fifo_full}, 0);
    acc(1, 1, 1, mon32_addr, 0);
    chk("R9 full at 4", {31'b0, fifo_full}, 1);
    chk("R9 no ovf yet", {31'b0, fifo_ovf}, 0);
    pulse_set();
    acc(1, 0, 0, {8'h00, mon24_addr}, 0);
    chk("R10 iso cleared", {31'b0, iso_stat}, 0);
    chk("R10 ovf", {31'b0, fifo_ovf}, 1);
    chk("R10 still full", {31'b0, fifo_full}, 1);
    pop_chk("R10 drop 1", 2'b00);
    pop_chk("R10 drop 2", 2'b01);
    pop_chk("R10 drop 3", 2'b10);
    pop_chk("R10 drop 4", 2'b11);
    chk("R10 fifth dropped", {31'b0, fifo_empty}, 1);
    chk("R10 ovf sticky", {31'b0, fifo_ovf}, 1);
  endtask

  task automatic t_both();
    acc(1, 1, 0, mon32_addr, 1);
    chk("R4 set wins", {31'b0, iso_stat}, 1);
    chk("R4 entry kept", {30'b0, fifo_data}, 32'd2);
    pop_chk("R4 pop", 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_block(1);
    t_miss();
    t_read_empty();
    t_hit32();
    t_block(0);
    t_set();
    t_block(1);
    t_order();
    pulse_set();
    t_full();
    t_both();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule